// File: doc/BRIEF.md
# Multi-Master Memory Bus Arbiter

This block connects several bus masters to a single slave port of a valid/ready memory bus. The bus has two streams. The command stream carries the address and the write data together on each beat. The response stream returns read data or a write completion. The arbiter picks one requesting master at a time with round-robin priority and forwards that master's command beat to the slave.

A write burst occupies several consecutive command beats. Once its first beat is accepted, the grant stays with the same master until the last beat has gone through. A read is always a single command beat, whatever its length field says. A command that the slave is stalling keeps its grant until the slave takes it.

The arbiter keeps no per-transaction state for responses. It widens the outgoing source ID by putting the master index in its upper bits. Each returning response is steered back by decoding those bits. Responses may therefore come back in any order. The master whose index matches receives the response valid, and its ready goes back to the slave.

Top module: `mbus_arbiter`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, the slave command valid, every master command ready and every master response valid are low. The first contest after reset is won by master 0.
- R2: The slave command port carries the granted master's opcode, address, length, data, mask and context unchanged. The outgoing source is {master index, master source}, with the index in the upper IDX_W bits. Only the granted master sees command ready.
- R3: When several masters keep requesting single-beat commands, grants rotate in ascending index order, starting after the master granted last and wrapping from the highest index to 0.
- R4: A write (opcode 1) whose length field is L occupies floor(L/BYTES)+1 consecutive accepted beats from the same master, with BYTES = DATA_W/8. This equals ceil((L+1)/BYTES). No other master's beat is forwarded in between.
- R5: A response is presented to exactly one master: the one whose index equals the upper IDX_W bits of the returned source. That master receives the lower SRC_W source bits, the opcode (0 success, 1 error), the data and the context unchanged.
- R6: While a response is presented, slave response ready equals the ready of the master it is routed to.
- R7: A response whose index bits name no existing master is accepted at once and raises no master's response valid.
- R8: A read (opcode 0) of any length and a write with L < BYTES release the grant after one accepted beat.
- R9: While the slave holds command ready low, the forwarded beat stays valid with the same source and address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cmd_valid | input | N_MASTERS | Command valid, one bit per master |
| m_cmd_ready | output | N_MASTERS | Command ready, one bit per master |
| m_cmd_source | input | N_MASTERS*SRC_W | Source IDs of the masters, master i in slice i |
| m_cmd_opcode | input | N_MASTERS | 0 read, 1 write |
| m_cmd_address | input | N_MASTERS*ADDR_W | First byte address |
| m_cmd_length | input | N_MASTERS*LEN_W | Byte count minus one |
| m_cmd_data | input | N_MASTERS*DATA_W | Write data |
| m_cmd_mask | input | N_MASTERS*(DATA_W/8) | Write byte enables |
| m_cmd_context | input | N_MASTERS*CTX_W | Master-defined tag returned with responses |
| m_rsp_valid | output | N_MASTERS | Response valid, one bit per master |
| m_rsp_ready | input | N_MASTERS | Response ready, one bit per master |
| m_rsp_source | output | SRC_W | Returned source with index bits removed |
| m_rsp_opcode | output | 1 | 0 success, 1 error |
| m_rsp_data | output | DATA_W | Read data |
| m_rsp_context | output | CTX_W | Returned context |
| s_cmd_valid | output | 1 | Slave command valid |
| s_cmd_ready | input | 1 | Slave command ready |
| s_cmd_source | output | SRC_W+IDX_W | Widened source |
| s_cmd_opcode | output | 1 | Forwarded opcode |
| s_cmd_address | output | ADDR_W | Forwarded address |
| s_cmd_length | output | LEN_W | Forwarded length |
| s_cmd_data | output | DATA_W | Forwarded write data |
| s_cmd_mask | output | DATA_W/8 | Forwarded mask |
| s_cmd_context | output | CTX_W | Forwarded context |
| s_rsp_valid | input | 1 | Slave response valid |
| s_rsp_ready | output | 1 | Slave response ready |
| s_rsp_source | input | SRC_W+IDX_W | Widened source of the response |
| s_rsp_opcode | input | 1 | Response status |
| s_rsp_data | input | DATA_W | Response data |
| s_rsp_context | input | CTX_W | Response context |

## Verification
The bench builds the arbiter with three masters. Two index bits then leave code 3 unused, which exercises the drain path for responses aimed at no master. With 32-bit data and a 4-bit length field, a burst spans one to four beats. This covers both an exact multiple of the beat size (length 11, three beats) and a partial last beat (length 4, two beats). Beat order is checked under continuous slave ready and under a ready that toggles every cycle.

// File: rtl/mbus_arb_pkg.sv
package mbus_arb_pkg;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } cmd_op_e;

   typedef enum logic {
      RSP_OK  = 1'b0,
      RSP_ERR = 1'b1
   } rsp_op_e;

   // Index bits needed to name n masters (at least one)
   function automatic int idx_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mbus_rr_pick.sv
module mbus_rr_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   input  logic [IDX_W-1:0] last,
   output logic [IDX_W-1:0] pick,
   output logic             found
);

   // Scan from the farthest candidate to the nearest so the nearest wins
   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int k = N; k >= 1; k--) begin
         logic [IDX_W-1:0] cand;
         cand = IDX_W'((int'(last) + k) % N);
         if (req[cand]) begin
            pick  = cand;
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mbus_grant_ctl.sv
module mbus_grant_ctl #(
   parameter int N     = 4,
   parameter int IDX_W = 2,
   parameter int LEN_W = 4,
   parameter int BLOG  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             out_ready,
   input  logic             sel_write,
   input  logic [LEN_W-1:0] sel_length,
   output logic [IDX_W-1:0] grant,
   output logic             grant_valid
);

   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] owner_q;
   logic [IDX_W-1:0] pick;
   logic             found;
   logic             stall_q;
   logic             burst_q;
   logic             more;
   logic             held;
   logic             fire;

   mbus_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
      .req   (req),
      .last  (last_q),
      .pick  (pick),
      .found (found)
   );

   assign held        = burst_q | stall_q;
   assign grant       = held ? owner_q : pick;
   assign grant_valid = held ? req[owner_q] : found;
   assign fire        = grant_valid & out_ready;

   generate
      if (LEN_W > BLOG) begin : g_burst
         localparam int RW = LEN_W - BLOG;
         logic [RW-1:0] rem_q;
         logic [RW-1:0] first_rem;

         assign first_rem = RW'(sel_length >> BLOG);
         assign more = burst_q ? (rem_q != RW'(1))
                               : (sel_write && (first_rem != '0));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rem_q   <= '0;
               burst_q <= 1'b0;
            end else if (fire) begin
               if (burst_q) begin
                  rem_q   <= rem_q - RW'(1);
                  burst_q <= (rem_q != RW'(1));
               end else if (sel_write && (first_rem != '0)) begin
                  rem_q   <= first_rem;
                  burst_q <= 1'b1;
               end
            end
         end
      end else begin : g_single
         logic unused_len;
         assign unused_len = ^{sel_length, sel_write};
         assign more       = 1'b0;
         assign burst_q    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q  <= IDX_W'(N - 1);
         owner_q <= '0;
         stall_q <= 1'b0;
      end else begin
         owner_q <= grant;
         stall_q <= grant_valid & ~out_ready;
         if (fire && !more) begin
            last_q <= grant;
         end
      end
   end

endmodule

// File: rtl/mbus_rsp_route.sv
module mbus_rsp_route #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic             s_valid,
   input  logic [IDX_W-1:0] idx,
   input  logic [N-1:0]     m_ready,
   output logic [N-1:0]     m_valid,
   output logic             s_ready
);

   logic hit_ready;

   always_comb begin
      hit_ready = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (idx == IDX_W'(i)) begin
            hit_ready = m_ready[i];
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_valid
      assign m_valid[g] = s_valid && (idx == IDX_W'(g));
   end

   generate
      if ((1 << IDX_W) == N) begin : g_full
         assign s_ready = hit_ready;
      end else begin : g_sparse
         logic known;
         assign known   = (idx < IDX_W'(N));
         assign s_ready = known ? hit_ready : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
   import mbus_arb_pkg::*;
#(
   parameter int N_MASTERS = 4,
   parameter int SRC_W     = 2,
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 6,
   parameter int DATA_W    = 32,
   parameter int CTX_W     = 4,
   localparam int IDX_W    = idx_bits(N_MASTERS),
   localparam int OSRC_W   = SRC_W + IDX_W,
   localparam int MASK_W   = DATA_W / 8,
   localparam int BLOG     = $clog2(MASK_W)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_MASTERS-1:0]          m_cmd_valid,
   output logic [N_MASTERS-1:0]          m_cmd_ready,
   input  logic [N_MASTERS*SRC_W-1:0]    m_cmd_source,
   input  logic [N_MASTERS-1:0]          m_cmd_opcode,
   input  logic [N_MASTERS*ADDR_W-1:0]   m_cmd_address,
   input  logic [N_MASTERS*LEN_W-1:0]    m_cmd_length,
   input  logic [N_MASTERS*DATA_W-1:0]   m_cmd_data,
   input  logic [N_MASTERS*MASK_W-1:0]   m_cmd_mask,
   input  logic [N_MASTERS*CTX_W-1:0]    m_cmd_context,
   output logic [N_MASTERS-1:0]          m_rsp_valid,
   input  logic [N_MASTERS-1:0]          m_rsp_ready,
   output logic [SRC_W-1:0]              m_rsp_source,
   output logic                          m_rsp_opcode,
   output logic [DATA_W-1:0]             m_rsp_data,
   output logic [CTX_W-1:0]              m_rsp_context,
   output logic                          s_cmd_valid,
   input  logic                          s_cmd_ready,
   output logic [OSRC_W-1:0]             s_cmd_source,
   output logic                          s_cmd_opcode,
   output logic [ADDR_W-1:0]             s_cmd_address,
   output logic [LEN_W-1:0]              s_cmd_length,
   output logic [DATA_W-1:0]             s_cmd_data,
   output logic [MASK_W-1:0]             s_cmd_mask,
   output logic [CTX_W-1:0]              s_cmd_context,
   input  logic                          s_rsp_valid,
   output logic                          s_rsp_ready,
   input  logic [OSRC_W-1:0]             s_rsp_source,
   input  logic                          s_rsp_opcode,
   input  logic [DATA_W-1:0]             s_rsp_data,
   input  logic [CTX_W-1:0]              s_rsp_context
);

   // Elaboration-time parameter checks
   if (N_MASTERS < 2) begin : g_bad_masters
      $error("mbus_arbiter: N_MASTERS must be at least 2");
   end
   if ((DATA_W < 8) || (DATA_W % 8 != 0) || ((1 << BLOG) != MASK_W)) begin : g_bad_data
      $error("mbus_arbiter: DATA_W must be a power-of-two multiple of 8");
   end
   if ((SRC_W < 1) || (LEN_W < 1) || (ADDR_W < 1) || (CTX_W < 1)) begin : g_bad_width
      $error("mbus_arbiter: field widths must be positive");
   end

   logic [IDX_W-1:0]  grant;
   logic              grant_valid;
   logic [SRC_W-1:0]  sel_src;
   logic              sel_op;
   logic [ADDR_W-1:0] sel_addr;
   logic [LEN_W-1:0]  sel_len;
   logic [DATA_W-1:0] sel_data;
   logic [MASK_W-1:0] sel_mask;
   logic [CTX_W-1:0]  sel_ctx;
   logic              sel_write;

   mbus_grant_ctl #(
      .N     (N_MASTERS),
      .IDX_W (IDX_W),
      .LEN_W (LEN_W),
      .BLOG  (BLOG)
   ) u_grant (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (m_cmd_valid),
      .out_ready   (s_cmd_ready),
      .sel_write   (sel_write),
      .sel_length  (sel_len),
      .grant       (grant),
      .grant_valid (grant_valid)
   );

   // Payload multiplexer driven by the current grant
   always_comb begin
      sel_src  = '0;
      sel_op   = 1'b0;
      sel_addr = '0;
      sel_len  = '0;
      sel_data = '0;
      sel_mask = '0;
      sel_ctx  = '0;
      for (int i = 0; i < N_MASTERS; i++) begin
         if (grant == IDX_W'(i)) begin
            sel_src  = m_cmd_source[i*SRC_W +: SRC_W];
            sel_op   = m_cmd_opcode[i];
            sel_addr = m_cmd_address[i*ADDR_W +: ADDR_W];
            sel_len  = m_cmd_length[i*LEN_W +: LEN_W];
            sel_data = m_cmd_data[i*DATA_W +: DATA_W];
            sel_mask = m_cmd_mask[i*MASK_W +: MASK_W];
            sel_ctx  = m_cmd_context[i*CTX_W +: CTX_W];
         end
      end
   end

   assign sel_write = (cmd_op_e'(sel_op) == OP_WRITE);

   assign s_cmd_valid   = grant_valid;
   assign s_cmd_source  = {grant, sel_src};
   assign s_cmd_opcode  = sel_op;
   assign s_cmd_address = sel_addr;
   assign s_cmd_length  = sel_len;
   assign s_cmd_data    = sel_data;
   assign s_cmd_mask    = sel_mask;
   assign s_cmd_context = sel_ctx;

   for (genvar g = 0; g < N_MASTERS; g++) begin : g_cmd_ready
      assign m_cmd_ready[g] = s_cmd_ready & grant_valid & (grant == IDX_W'(g));
   end

   // Stateless response return path
   mbus_rsp_route #(.N(N_MASTERS), .IDX_W(IDX_W)) u_route (
      .s_valid (s_rsp_valid),
      .idx     (s_rsp_source[OSRC_W-1 -: IDX_W]),
      .m_ready (m_rsp_ready),
      .m_valid (m_rsp_valid),
      .s_ready (s_rsp_ready)
   );

   assign m_rsp_source  = s_rsp_source[SRC_W-1:0];
   assign m_rsp_opcode  = s_rsp_opcode;
   assign m_rsp_data    = s_rsp_data;
   assign m_rsp_context = s_rsp_context;

endmodule

// File: rtl/mbus_arbiter_chk.sv
module mbus_arbiter_chk #(
   parameter int N_MASTERS = 4,
   parameter int SRC_W     = 2,
   parameter int IDX_W     = 2,
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 6,
   parameter int BLOG      = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_MASTERS-1:0]     m_cmd_valid,
   input logic [N_MASTERS-1:0]     m_cmd_ready,
   input logic [N_MASTERS-1:0]     m_rsp_valid,
   input logic [N_MASTERS-1:0]     m_rsp_ready,
   input logic                     s_cmd_valid,
   input logic                     s_cmd_ready,
   input logic [SRC_W+IDX_W-1:0]   s_cmd_source,
   input logic                     s_cmd_opcode,
   input logic [ADDR_W-1:0]        s_cmd_address,
   input logic [LEN_W-1:0]         s_cmd_length,
   input logic                     s_rsp_valid,
   input logic                     s_rsp_ready,
   input logic [IDX_W-1:0]         rsp_idx
);

   logic [IDX_W-1:0] cmd_idx;
   logic [LEN_W-1:0] left_q;
   logic [IDX_W-1:0] owner_q;

   assign cmd_idx = s_cmd_source[SRC_W+IDX_W-1 -: IDX_W];

   // Independent beat tracker for bursts seen on the slave side
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q  <= '0;
         owner_q <= '0;
      end else if (s_cmd_valid && s_cmd_ready) begin
         if (left_q != '0) begin
            left_q <= left_q - LEN_W'(1);
         end else if (s_cmd_opcode) begin
            left_q  <= s_cmd_length >> BLOG;
            owner_q <= cmd_idx;
         end
      end
   end

   p_cmd_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s_cmd_valid |-> m_cmd_valid[cmd_idx])
      else $error("forwarded beat from a master that is not requesting");

   p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|m_cmd_ready) |-> (s_cmd_ready && s_cmd_valid && $onehot(m_cmd_ready)))
      else $error("master ready without slave acceptance");

   p_burst_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_cmd_valid && (left_q != '0)) |-> (cmd_idx == owner_q))
      else $error("grant left the owner in the middle of a write burst");

   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_cmd_valid && !s_cmd_ready) |=>
         (s_cmd_valid && $stable(s_cmd_source) && $stable(s_cmd_address)))
      else $error("stalled command changed before acceptance");

   p_rsp_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_rsp_valid))
      else $error("response offered to more than one master");

   p_rsp_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rsp_valid && (int'(rsp_idx) < N_MASTERS)) |-> m_rsp_valid[rsp_idx])
      else $error("response not offered to the indexed master");

   p_rsp_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rsp_valid && (int'(rsp_idx) < N_MASTERS)) |-> (s_rsp_ready == m_rsp_ready[rsp_idx]))
      else $error("slave response ready differs from the routed master");

   p_rsp_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rsp_valid && (int'(rsp_idx) >= N_MASTERS)) |-> (s_rsp_ready && (m_rsp_valid == '0)))
      else $error("response with unused index not drained");

endmodule

bind mbus_arbiter mbus_arbiter_chk #(
   .N_MASTERS (N_MASTERS),
   .SRC_W     (SRC_W),
   .IDX_W     (IDX_W),
   .ADDR_W    (ADDR_W),
   .LEN_W     (LEN_W),
   .BLOG      (BLOG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .m_cmd_valid   (m_cmd_valid),
   .m_cmd_ready   (m_cmd_ready),
   .m_rsp_valid   (m_rsp_valid),
   .m_rsp_ready   (m_rsp_ready),
   .s_cmd_valid   (s_cmd_valid),
   .s_cmd_ready   (s_cmd_ready),
   .s_cmd_source  (s_cmd_source),
   .s_cmd_opcode  (s_cmd_opcode),
   .s_cmd_address (s_cmd_address),
   .s_cmd_length  (s_cmd_length),
   .s_rsp_valid   (s_rsp_valid),
   .s_rsp_ready   (s_rsp_ready),
   .rsp_idx       (s_rsp_source[SRC_W+IDX_W-1 -: IDX_W])
);

// File: tb/test_mbus_arbiter.sv
module test_mbus_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam int NM  = 3;
   localparam int SW  = 2;
   localparam int AW  = 16;
   localparam int LW  = 4;
   localparam int DW  = 32;
   localparam int CW  = 3;
   localparam int IW  = 2;
   localparam int OSW = SW + IW;
   localparam int MW  = DW / 8;
   localparam int BW  = SW + 1 + AW + LW + DW + MW + CW;

   typedef logic [BW-1:0]    beat_t;
   typedef logic [BW+IW-1:0] sbeat_t;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NM-1:0]     m_cmd_valid;
   logic [NM-1:0]     m_cmd_ready;
   logic [NM*SW-1:0]  m_cmd_source;
   logic [NM-1:0]     m_cmd_opcode;
   logic [NM*AW-1:0]  m_cmd_address;
   logic [NM*LW-1:0]  m_cmd_length;
   logic [NM*DW-1:0]  m_cmd_data;
   logic [NM*MW-1:0]  m_cmd_mask;
   logic [NM*CW-1:0]  m_cmd_context;
   logic [NM-1:0]     m_rsp_valid;
   logic [NM-1:0]     m_rsp_ready;
   logic [SW-1:0]     m_rsp_source;
   logic              m_rsp_opcode;
   logic [DW-1:0]     m_rsp_data;
   logic [CW-1:0]     m_rsp_context;
   logic              s_cmd_valid;
   logic              s_cmd_ready;
   logic [OSW-1:0]    s_cmd_source;
   logic              s_cmd_opcode;
   logic [AW-1:0]     s_cmd_address;
   logic [LW-1:0]     s_cmd_length;
   logic [DW-1:0]     s_cmd_data;
   logic [MW-1:0]     s_cmd_mask;
   logic [CW-1:0]     s_cmd_context;
   logic              s_rsp_valid;
   logic              s_rsp_ready;
   logic [OSW-1:0]    s_rsp_source;
   logic              s_rsp_opcode;
   logic [DW-1:0]     s_rsp_data;
   logic [CW-1:0]     s_rsp_context;

   int     n_chk  = 0;
   int     n_fail = 0;
   string  cur_req = "R2";
   logic   stall = 1'b0;
   beat_t  mq [NM][$];
   sbeat_t exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mbus_arbiter #(
      .N_MASTERS (NM), .SRC_W (SW), .ADDR_W (AW),
      .LEN_W (LW), .DATA_W (DW), .CTX_W (CW)
   ) i_mbus_arbiter (
      .clk (clk), .rst_n (rst_n),
      .m_cmd_valid (m_cmd_valid), .m_cmd_ready (m_cmd_ready),
      .m_cmd_source (m_cmd_source), .m_cmd_opcode (m_cmd_opcode),
      .m_cmd_address (m_cmd_address), .m_cmd_length (m_cmd_length),
      .m_cmd_data (m_cmd_data), .m_cmd_mask (m_cmd_mask),
      .m_cmd_context (m_cmd_context),
      .m_rsp_valid (m_rsp_valid), .m_rsp_ready (m_rsp_ready),
      .m_rsp_source (m_rsp_source), .m_rsp_opcode (m_rsp_opcode),
      .m_rsp_data (m_rsp_data), .m_rsp_context (m_rsp_context),
      .s_cmd_valid (s_cmd_valid), .s_cmd_ready (s_cmd_ready),
      .s_cmd_source (s_cmd_source), .s_cmd_opcode (s_cmd_opcode),
      .s_cmd_address (s_cmd_address), .s_cmd_length (s_cmd_length),
      .s_cmd_data (s_cmd_data), .s_cmd_mask (s_cmd_mask),
      .s_cmd_context (s_cmd_context),
      .s_rsp_valid (s_rsp_valid), .s_rsp_ready (s_rsp_ready),
      .s_rsp_source (s_rsp_source), .s_rsp_opcode (s_rsp_opcode),
      .s_rsp_data (s_rsp_data), .s_rsp_context (s_rsp_context)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic beat_t mk(input logic [SW-1:0] src, input logic op, input logic [AW-1:0] a,
                                input logic [LW-1:0] l, input logic [DW-1:0] d,
                                input logic [MW-1:0] msk, input logic [CW-1:0] c);
      return {src, op, a, l, d, msk, c};
   endfunction

   task automatic put(input int m, input beat_t b);
      mq[m].push_back(b);
   endtask

   task automatic want(input int m, input beat_t b);
      exp_q.push_back({IW'(m), b});
   endtask

   task automatic drain();
      int t = 0;
      while (((mq[0].size() + mq[1].size() + mq[2].size() + exp_q.size()) != 0) && (t < 400)) begin
         @(negedge clk);
         t++;
      end
      chk(exp_q.size() == 0, {cur_req, " all expected beats seen"}, exp_q.size(), 0);
   endtask

   // Master driver: one process for all masters, holds each beat until accepted
   initial begin
      logic [NM-1:0] acc;
      m_cmd_valid = '0; m_cmd_source = '0; m_cmd_opcode = '0; m_cmd_address = '0;
      m_cmd_length = '0; m_cmd_data = '0; m_cmd_mask = '0; m_cmd_context = '0;
      s_cmd_ready = 1'b0;
      forever begin
         @(negedge clk);
         acc = m_cmd_valid & m_cmd_ready;
         @(posedge clk);
         #1;
         if (rst_n) s_cmd_ready = stall ? ~s_cmd_ready : 1'b1;
         for (int m = 0; m < NM; m++) begin
            if (acc[m]) void'(mq[m].pop_front());
            if (mq[m].size() != 0) begin
               {m_cmd_source[m*SW +: SW], m_cmd_opcode[m], m_cmd_address[m*AW +: AW],
                m_cmd_length[m*LW +: LW], m_cmd_data[m*DW +: DW], m_cmd_mask[m*MW +: MW],
                m_cmd_context[m*CW +: CW]} = mq[m][0];
               m_cmd_valid[m] = 1'b1;
            end else begin
               m_cmd_valid[m] = 1'b0;
            end
         end
      end
   end

   // Monitor: compares every accepted slave beat with the scoreboard head
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && s_cmd_valid && s_cmd_ready) begin
            sbeat_t act;
            sbeat_t e;
            act = {s_cmd_source, s_cmd_opcode, s_cmd_address, s_cmd_length,
                   s_cmd_data, s_cmd_mask, s_cmd_context};
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_req, " unexpected beat"}, act, 0);
            end else begin
               e = exp_q.pop_front();
               chk(act === e, {cur_req, " beat order and fields"}, act, e);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      beat_t b;
      rst_n = 1'b0;
      s_rsp_valid = 1'b0; s_rsp_source = '0; s_rsp_opcode = 1'b0;
      s_rsp_data = '0; s_rsp_context = '0; m_rsp_ready = '0;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(s_cmd_valid == 1'b0, "R1 cmd valid in reset", s_cmd_valid, 0);
      chk(m_cmd_ready == '0, "R1 master ready in reset", m_cmd_ready, 0);
      chk(m_rsp_valid == '0, "R1 rsp valid in reset", m_rsp_valid, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk(s_cmd_valid == 1'b0 && m_cmd_ready == '0, "R1 idle after reset",
          {s_cmd_valid, m_cmd_ready}, 0);

      // R1 + R3 + R2: two single reads per master, all requesting together
      cur_req = "R3";
      for (int r = 0; r < 2; r++) begin
         for (int m = 0; m < NM; m++) begin
            b = mk(SW'(m + r), 1'b0, AW'(16'h100 * m + r), LW'(0), DW'(32'hA000 + 16 * m + r),
                   MW'(0), CW'(m));
            put(m, b);
            want(m, b);
         end
      end
      drain();

      // R4 + R8: 3-beat write burst (length 11) from master 0 holds the grant
      cur_req = "R4";
      for (int k = 0; k < 3; k++) begin
         b = mk(2'd1, 1'b1, 16'h2000, 4'd11, DW'(32'hB0B0_0000 + k), 4'hF, 3'd2);
         put(0, b);
         want(0, b);
      end
      b = mk(2'd2, 1'b0, 16'h3000, 4'd15, 32'h0, 4'h0, 3'd4);
      put(1, b); want(1, b);
      b = mk(2'd3, 1'b0, 16'h4000, 4'd0, 32'h0, 4'h0, 3'd5);
      put(2, b); want(2, b);
      drain();

      // R8: single-beat write (length 3) releases after one beat
      cur_req = "R8";
      b = mk(2'd0, 1'b1, 16'h5000, 4'd3, 32'h1111_2222, 4'h3, 3'd1);
      put(0, b); want(0, b);
      b = mk(2'd1, 1'b0, 16'h5100, 4'd7, 32'h0, 4'h0, 3'd6);
      put(1, b); want(1, b);
      drain();

      // R4: length 4 rounds up to two beats
      cur_req = "R4";
      for (int k = 0; k < 2; k++) begin
         b = mk(2'd2, 1'b1, 16'h6000, 4'd4, DW'(32'hC0C0_0000 + k), 4'hF, 3'd7);
         put(2, b);
         want(2, b);
      end
      b = mk(2'd3, 1'b0, 16'h6100, 4'd1, 32'h0, 4'h0, 3'd0);
      put(0, b); want(0, b);
      drain();

      // R9: slave ready toggles; order and burst hold unchanged
      cur_req = "R9";
      stall = 1'b1;
      b = mk(2'd0, 1'b0, 16'h7000, 4'd0, 32'h0, 4'h0, 3'd1);
      put(0, b);
      b = mk(2'd1, 1'b0, 16'h7100, 4'd0, 32'h0, 4'h0, 3'd2);
      put(1, b); want(1, b);
      for (int k = 0; k < 2; k++) begin
         b = mk(2'd2, 1'b1, 16'h7200, 4'd7, DW'(32'hD0D0_0000 + k), 4'hC, 3'd3);
         put(2, b);
         want(2, b);
      end
      want(0, mk(2'd0, 1'b0, 16'h7000, 4'd0, 32'h0, 4'h0, 3'd1));
      drain();
      stall = 1'b0;

      // R5 + R6: response to master 1
      cur_req = "R5";
      @(posedge clk); #1;
      s_rsp_valid = 1'b1; s_rsp_source = {2'd1, 2'd3}; s_rsp_opcode = 1'b1;
      s_rsp_data = 32'hCAFE_0001; s_rsp_context = 3'd5; m_rsp_ready = 3'b010;
      @(negedge clk);
      chk(m_rsp_valid == 3'b010, "R5 route to master 1", m_rsp_valid, 3'b010);
      chk(m_rsp_source == 2'd3 && m_rsp_opcode == 1'b1, "R5 source and opcode",
          {m_rsp_source, m_rsp_opcode}, {2'd3, 1'b1});
      chk(m_rsp_data == 32'hCAFE_0001 && m_rsp_context == 3'd5, "R5 data and context",
          {m_rsp_data, m_rsp_context}, {32'hCAFE_0001, 3'd5});
      chk(s_rsp_ready == 1'b1, "R6 ready from master 1", s_rsp_ready, 1);
      @(posedge clk); #1;
      m_rsp_ready = 3'b101;
      @(negedge clk);
      chk(s_rsp_ready == 1'b0, "R6 backpressure from master 1", s_rsp_ready, 0);
      chk(m_rsp_valid == 3'b010, "R5 valid held under backpressure", m_rsp_valid, 3'b010);

      // R5 + R6: response to master 2
      @(posedge clk); #1;
      s_rsp_source = {2'd2, 2'd0}; s_rsp_opcode = 1'b0; m_rsp_ready = 3'b100;
      @(negedge clk);
      chk(m_rsp_valid == 3'b100, "R5 route to master 2", m_rsp_valid, 3'b100);
      chk(s_rsp_ready == 1'b1, "R6 ready from master 2", s_rsp_ready, 1);

      // R7: index 3 names no master
      @(posedge clk); #1;
      s_rsp_source = {2'd3, 2'd1}; m_rsp_ready = 3'b000;
      @(negedge clk);
      chk(m_rsp_valid == 3'b000, "R7 no master offered", m_rsp_valid, 0);
      chk(s_rsp_ready == 1'b1, "R7 drained", s_rsp_ready, 1);

      @(posedge clk); #1;
      s_rsp_valid = 1'b0;
      @(negedge clk);
      chk(m_rsp_valid == 3'b000, "R5 idle response path", m_rsp_valid, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule